// File: doc/BRIEF.md
# Accumulator and Register Processor Core

This block is a very small processor core. It has two working registers: an accumulator and one general register. It also has an output register that drives the data output, and a carry flag. Each clock cycle it executes exactly one instruction, chosen by a 4-bit code. It has no instruction fetch and no memory. The surrounding logic, or a tester, presents a new code and a data word on every cycle.

The ten instructions do four kinds of work:
- load the accumulator or the general register from the data input;
- copy the accumulator into the general register;
- drive the output register from either working register;
- change the accumulator by addition, OR, AND or complement, using the general register as the second operand.

Every update takes effect at the clock edge that ends the cycle in which the code is presented. So a short chain of codes can load operands, apply one operation and make the result visible on the output. This lets each function be observed at the port.

Top module: `acc_reg_cpu`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the general register, the output register and the carry flag. After reset, dataOut and carry read 0, and outputting either working register gives 0.
- R2: Codes 1 and 6 load the accumulator from dataIn at the next clock edge.
- R3: Code 2 copies the accumulator into the general register. Code 5 loads the general register from dataIn.
- R4: Code 3 loads the output register from the general register. Code 4 loads it from the accumulator. dataOut shows the new value right after that edge.
- R5: Code 7 writes the low DATA_W bits of accumulator + general register into the accumulator. The bit above them goes into the carry flag.
- R6: Code 8 sets the accumulator to accumulator OR general register. Code 9 sets it to accumulator AND general register.
- R7: Code 10 replaces the accumulator with its bitwise complement.
- R8: A register that an instruction does not write keeps its value:
  - the general register changes only on codes 2 and 5;
  - the output register changes only on codes 3 and 4;
  - the carry flag changes only on code 7.
- R9: Codes 0 and 11 to 15 change no state.
- R10: Codes 5, 1, 7, 4 on consecutive cycles place the sum on dataOut three clock edges after the edge that loaded the general register. With 3-bit data, 110 in the general register and 101 in the accumulator give these distinct results:
  - ADD gives 011 with carry 1;
  - OR gives 111;
  - AND gives 100;
  - complement gives 010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Instruction code executed this cycle |
| dataIn | input | DATA_W | Input data word |
| dataOut | output | DATA_W | Output register |
| carry | output | 1 | Carry of the last addition |

## Verification
Two things can land on the same clock edge.

The first is an addition. Code 7 writes the accumulator and the carry flag at the same edge. The bench runs additions with and without overflow and compares both the flag and the accumulator, which is brought out with code 4 on the next cycle.

The second is a write followed at once by an output. Code 4 or code 3 in the cycle right after a write to that register must show the freshly written value, not the old one. Directed chains and a long random code stream provoke this back-to-back case. A behavioural model judges every cycle.

// File: rtl/acc_reg_cpu_pkg.sv
package acc_reg_cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LDA_A  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_MOV_RA = 4'd2;
  localparam logic [OPC_W-1:0] OPC_OUT_R  = 4'd3;
  localparam logic [OPC_W-1:0] OPC_OUT_A  = 4'd4;
  localparam logic [OPC_W-1:0] OPC_LDR    = 4'd5;
  localparam logic [OPC_W-1:0] OPC_LDA_B  = 4'd6;
  localparam logic [OPC_W-1:0] OPC_ADD    = 4'd7;
  localparam logic [OPC_W-1:0] OPC_OR     = 4'd8;
  localparam logic [OPC_W-1:0] OPC_AND    = 4'd9;
  localparam logic [OPC_W-1:0] OPC_NOT    = 4'd10;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_OR  = 2'd1,
    ALU_AND = 2'd2,
    ALU_NOT = 2'd3
  } aluSel_e;

  typedef struct packed {
    logic    aFromIn;
    logic    aFromAlu;
    aluSel_e aluSel;
    logic    rFromA;
    logic    rFromIn;
    logic    outFromA;
    logic    outFromR;
    logic    carryWr;
  } strobes_t;
endpackage

// File: rtl/acc_reg_cpu_ctrl.sv
module acc_reg_cpu_ctrl
  import acc_reg_cpu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output strobes_t         strobes
);
  always_comb begin
    strobes = '0;
    strobes.aluSel = ALU_ADD;
    unique case (opcode)
      OPC_LDA_A, OPC_LDA_B: strobes.aFromIn = 1'b1;
      OPC_MOV_RA:           strobes.rFromA = 1'b1;
      OPC_OUT_R:            strobes.outFromR = 1'b1;
      OPC_OUT_A:            strobes.outFromA = 1'b1;
      OPC_LDR:              strobes.rFromIn = 1'b1;
      OPC_ADD: begin
        strobes.aFromAlu = 1'b1;
        strobes.aluSel   = ALU_ADD;
        strobes.carryWr  = 1'b1;
      end
      OPC_OR: begin
        strobes.aFromAlu = 1'b1;
        strobes.aluSel   = ALU_OR;
      end
      OPC_AND: begin
        strobes.aFromAlu = 1'b1;
        strobes.aluSel   = ALU_AND;
      end
      OPC_NOT: begin
        strobes.aFromAlu = 1'b1;
        strobes.aluSel   = ALU_NOT;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/acc_reg_cpu_dpath.sv
module acc_reg_cpu_dpath
  import acc_reg_cpu_pkg::*;
#(
  parameter int DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              carry
);
  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] regA, regR, regOut, aluRes;
  logic [SUM_W-1:0]  sum;
  logic              carryQ;

  assign sum = {1'b0, regA} + {1'b0, regR};

  always_comb begin
    unique case (strobes.aluSel)
      ALU_ADD: aluRes = sum[DATA_W-1:0];
      ALU_OR:  aluRes = regA | regR;
      ALU_AND: aluRes = regA & regR;
      default: aluRes = ~regA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regA   <= '0;
      regR   <= '0;
      regOut <= '0;
      carryQ <= 1'b0;
    end else begin
      if (strobes.aFromIn)       regA <= dataIn;
      else if (strobes.aFromAlu) regA <= aluRes;
      if (strobes.rFromIn)       regR <= dataIn;
      else if (strobes.rFromA)   regR <= regA;
      if (strobes.outFromA)      regOut <= regA;
      else if (strobes.outFromR) regOut <= regR;
      if (strobes.carryWr)       carryQ <= sum[SUM_W-1];
    end
  end

  assign dataOut = regOut;
  assign carry   = carryQ;
endmodule

// File: rtl/acc_reg_cpu.sv
module acc_reg_cpu
  import acc_reg_cpu_pkg::*;
#(
  parameter int DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              carry
);
  strobes_t strobes;

  acc_reg_cpu_ctrl i_ctrl (
    .opcode  (opcode),
    .strobes (strobes)
  );

  acc_reg_cpu_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .carry   (carry)
  );
endmodule

// File: rtl/acc_reg_cpu_chk.sv
module acc_reg_cpu_chk #(
  parameter int DATA_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        opcode,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] dataOut,
  input logic              carry
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dataOut == '0 && carry == 1'b0));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode != 4'd3 && opcode != 4'd4) |=> $stable(dataOut));

  // R8
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode != 4'd7) |=> $stable(carry));

  // R2
  load_then_out_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'd1 || opcode == 4'd6) ##1 (opcode == 4'd4)
      |=> dataOut == $past(dataIn, 2));

  // R3
  r_load_out_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'd5) ##1 (opcode == 4'd3) |=> dataOut == $past(dataIn, 2));

  // R7
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'd1) ##1 (opcode == 4'd10) ##1 (opcode == 4'd4)
      |=> dataOut == DATA_W'(~$past(dataIn, 3)));
endmodule

bind acc_reg_cpu acc_reg_cpu_chk #(.DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .opcode  (opcode),
  .dataIn  (dataIn),
  .dataOut (dataOut),
  .carry   (carry)
);

// File: tb/test_acc_reg_cpu.sv
module test_acc_reg_cpu;
  localparam int W = 3;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   opcode = 4'd0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] dataOut;
  logic         carry;

  int checks = 0;
  int errors = 0;
  int mA = 0, mR = 0, mOut = 0, mC = 0;

  always #10 clk = ~clk;

  acc_reg_cpu #(.DATA_W(W)) i_acc_reg_cpu (
    .clk(clk), .rst(rst), .opcode(opcode), .dataIn(dataIn),
    .dataOut(dataOut), .carry(carry)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int op, int din, string req);
    opcode = op[3:0];
    dataIn = din[W-1:0];
    @(posedge clk);
    case (op)
      1, 6: mA = din & MASK;
      2:    mR = mA;
      3:    mOut = mR;
      4:    mOut = mA;
      5:    mR = din & MASK;
      7: begin
        mC = ((mA + mR) >> W) & 1;
        mA = (mA + mR) & MASK;
      end
      8:    mA = mA | mR;
      9:    mA = mA & mR;
      10:   mA = (~mA) & MASK;
      default: ;
    endcase
    @(negedge clk);
    check({req, " dataOut"}, int'(dataOut), mOut);
    check({req, " carry"}, int'(carry), mC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: dirty state, then reset
    rst = 1'b0;
    step(5, 7, "R3"); step(1, 7, "R2"); step(7, 0, "R5"); step(4, 0, "R4");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    mA = 0; mR = 0; mOut = 0; mC = 0;
    check("R1 dataOut", int'(dataOut), 0);
    check("R1 carry", int'(carry), 0);
    step(4, 5, "R1"); step(3, 5, "R1");

    // R10: load R=110, A=101, add, output; sum on OUT
    step(5, 6, "R10"); step(1, 5, "R10"); step(7, 2, "R10"); step(4, 0, "R10");
    check("R10 sum", int'(dataOut), 3);
    check("R10 carry", int'(carry), 1);
    // R6 OR and AND
    step(6, 5, "R6"); step(8, 0, "R6"); step(4, 0, "R6");
    check("R6 OR", int'(dataOut), 7);
    step(1, 5, "R6"); step(9, 0, "R6"); step(4, 0, "R6");
    check("R6 AND", int'(dataOut), 4);
    // R7 complement
    step(1, 5, "R7"); step(10, 0, "R7"); step(4, 0, "R7");
    check("R7 NOT", int'(dataOut), 2);
    // R3 copy A to R, R output
    step(1, 3, "R3"); step(2, 0, "R3"); step(1, 0, "R3"); step(3, 0, "R3");
    check("R3 copy", int'(dataOut), 3);
    // R5 add without carry clears flag
    step(1, 1, "R5"); step(7, 0, "R5"); step(4, 0, "R5");
    check("R5 sum", int'(dataOut), 4);
    check("R5 carry", int'(carry), 0);
    // R9 no-op codes leave all state
    for (int c = 11; c < 16; c++) step(c, 7, "R9");
    step(0, 7, "R9");
    step(4, 0, "R9"); check("R9 A kept", int'(dataOut), 4);
    step(3, 0, "R9"); check("R9 R kept", int'(dataOut), 3);
    // R8 random stream against model
    for (int i = 0; i < 2000; i++) step(int'($urandom_range(0, 15)), int'($urandom_range(0, MASK)), "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule